// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block holds six breakpoint slots. Each slot has a 32-bit control word and a 64-bit value word. Every valid instruction fetch is compared against all slots at once. A fetch carries the program counter, the current context identifier and the current virtual-machine identifier. Software programs the slots through a small read/write port. The block registers a one-bit hit per slot and a single combined breakpoint event.

The type field of a slot selects what it compares. The choices are:
- the instruction address, tested for equality or for inequality;
- the context identifier;
- the virtual-machine identifier;
- the context identifier and the virtual-machine identifier together.

An address slot can be linked to another slot that holds a context comparison. It then fires only when both agree. A two-bit halfword select lets one address slot fire on the lower half of a 4-byte-aligned word, the upper half, or both. Security-state and privilege qualifiers are stored and read back, but they do not filter hits.

Top module: `bkpt_match_unit`

## Requirements
- R1: While reset is held, `hit_vec` and `bkpt_event` are 0.
- R2: A control read returns the following fields, and all other bits read 0:
  - type in [23:20]
  - link index in [19:16]
  - qualifier bits [15:13]
  - halfword select in [8:5]
  - qualifier bits [2:1]
  - enable in [0]

  Halfword-select bits 8 and 6 ignore writes. On a read they return bits 7 and 5.
- R3: A value read returns all 64 bits last written to that slot.
- R4: A slot whose enable bit is 0 never hits.
- R5: Type 0000 (unlinked address equality) hits when both of the following hold:
  - `fetch_pc[47:2]` equals value bits [47:2];
  - the select bit for the fetched half is set. That bit is control bit 5 when `fetch_pc[1]`=0 and control bit 7 when `fetch_pc[1]`=1.
- R6: Type 0100 (unlinked address inequality) hits exactly when the R5 address comparison is false.
- R7: The context types compare against fields of the value word:
  - Type 0010 hits when `fetch_ctxid` equals value bits [31:0].
  - Type 1000 hits when `fetch_vmid` equals value bits [39:32].
  - Type 1010 requires both equalities.
- R8: Types 0001 and 0101 are the linked forms of R5 and R6. They hit only when all of the following hold:
  - their own address condition holds;
  - the slot named by their link index is below 6 and enabled;
  - that slot has type 0011, 1001 or 1011;
  - that slot's context comparison is true.
- R9: Types 0011, 1001 and 1011 never hit on their own.
- R10: All type codes not named in R5 to R9 never hit.
- R11: Hits appear on the clock edge after the edge that samples `fetch_valid`=1. A cycle without `fetch_valid` yields an all-zero `hit_vec`.
- R12: `bkpt_event` is 1 exactly when `hit_vec` is nonzero.

Ports are listed below, with the parameters at their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the hit outputs |
| reg_wr | input | 1 | Write strobe for the slot register port |
| reg_sel_val | input | 1 | 1 selects the value word, 0 selects the control word |
| reg_idx | input | 3 | Slot index for the read and the write |
| reg_wdata | input | 64 | Write data (the control word uses bits [31:0]) |
| reg_rdata | output | 64 | Combinational read data of the selected word |
| fetch_valid | input | 1 | Fetch qualifier |
| fetch_pc | input | 48 | Fetched instruction address |
| fetch_ctxid | input | 32 | Current context identifier |
| fetch_vmid | input | 8 | Current virtual-machine identifier |
| hit_vec | output | 6 | Registered per-slot hits |
| bkpt_event | output | 1 | Registered OR of all slot hits |

## Verification
The bench uses the default parameters: six slots, a 48-bit address, a 32-bit context identifier and an 8-bit machine identifier. The 3-bit slot index and the 4-bit link field can both name slots 6 and 7, which do not exist, so out-of-range links are exercised as well as links to slots 3 and 5. The wide address makes it possible to differ from the programmed word only in its upper bits. The value word carries both identifiers at once, so a single slot can check the combined context type.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef struct packed {
        logic [3:0] kind;
        logic [3:0] link_idx;
        logic [2:0] scope;
        logic       half_hi;
        logic       half_lo;
        logic [1:0] level;
        logic       en;
    } bp_ctrl_t;

    typedef enum logic [1:0] {
        BASE_ADDR = 2'b00,
        BASE_CTX  = 2'b01,
        BASE_VMID = 2'b10,
        BASE_BOTH = 2'b11
    } bp_base_e;

    typedef struct packed {
        logic     legal;
        logic     linked;
        logic     mism;
        bp_base_e base;
    } bp_kind_t;

    function automatic bp_kind_t decode_kind(input logic [3:0] k);
        bp_kind_t d;
        d.linked = k[0];
        d.mism   = k[2];
        d.base   = bp_base_e'({k[3], k[1]});
        case (k)
            4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100,
            4'b0101, 4'b1000, 4'b1001, 4'b1010, 4'b1011: d.legal = 1'b1;
            default:                                      d.legal = 1'b0;
        endcase
        return d;
    endfunction

    function automatic bp_ctrl_t ctrl_unpack(input logic [31:0] w);
        bp_ctrl_t c;
        c.kind     = w[23:20];
        c.link_idx = w[19:16];
        c.scope    = w[15:13];
        c.half_hi  = w[7];
        c.half_lo  = w[5];
        c.level    = w[2:1];
        c.en       = w[0];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input bp_ctrl_t c);
        logic [31:0] w;
        w        = '0;
        w[23:20] = c.kind;
        w[19:16] = c.link_idx;
        w[15:13] = c.scope;
        w[8]     = c.half_hi;
        w[7]     = c.half_hi;
        w[6]     = c.half_lo;
        w[5]     = c.half_lo;
        w[2:1]   = c.level;
        w[0]     = c.en;
        return w;
    endfunction

endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
    import bkpt_pkg::*;
#(
    parameter int NUM_PAIRS = 6,
    parameter int VAL_W     = 64,
    parameter int IDX_W     = 3
) (
    input  logic                              clk,
    input  logic                              wr_en,
    input  logic                              sel_val,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [VAL_W-1:0]                  wdata,
    output logic [VAL_W-1:0]                  rdata,
    output bp_ctrl_t [NUM_PAIRS-1:0]          ctrl_o,
    output logic [NUM_PAIRS-1:0][VAL_W-1:0]   val_o
);

    typedef struct packed {
        bp_ctrl_t [NUM_PAIRS-1:0]        ctrl;
        logic [NUM_PAIRS-1:0][VAL_W-1:0] val;
    } bank_t;

    bank_t bank_d, bank_q;

    // Next-state and read mux; slots past NUM_PAIRS read zero and take no write.
    always_comb begin
        bank_d = bank_q;
        rdata  = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (wr_en && int'(idx) == p) begin
                if (sel_val) begin
                    bank_d.val[p] = wdata;
                end else begin
                    bank_d.ctrl[p] = ctrl_unpack(wdata[31:0]);
                end
            end
            if (int'(idx) == p) begin
                rdata = sel_val ? bank_q.val[p] : VAL_W'(ctrl_pack(bank_q.ctrl[p]));
            end
        end
    end

    // Slot contents carry no reset: software programs every slot before use.
    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    assign ctrl_o = bank_q.ctrl;
    assign val_o  = bank_q.val;

endmodule

// File: rtl/bkpt_pair_cmp.sv
module bkpt_pair_cmp
    import bkpt_pkg::*;
#(
    parameter int PC_W   = 48,
    parameter int VAL_W  = 64,
    parameter int CTX_W  = 32,
    parameter int VMID_W = 8
) (
    input  bp_ctrl_t          ctrl,
    input  logic [VAL_W-1:0]  val,
    input  logic [PC_W-1:0]   pc,
    input  logic [CTX_W-1:0]  ctxid,
    input  logic [VMID_W-1:0] vmid,
    output bp_kind_t          kind,
    output logic              addr_eq,
    output logic              ctx_eq
);

    logic word_eq, half_ok, ctxid_eq, vmid_eq;
    logic unused_bits;

    assign unused_bits = ^{pc[0], val[VAL_W-1:PC_W], ctrl.scope, ctrl.level, ctrl.en, ctrl.link_idx};

    always_comb begin
        kind     = decode_kind(ctrl.kind);
        word_eq  = (pc[PC_W-1:2] == val[PC_W-1:2]);
        half_ok  = pc[1] ? ctrl.half_hi : ctrl.half_lo;
        addr_eq  = word_eq & half_ok;
        ctxid_eq = (ctxid == val[CTX_W-1:0]);
        vmid_eq  = (vmid == val[CTX_W +: VMID_W]);
        case (kind.base)
            BASE_CTX:  ctx_eq = ctxid_eq;
            BASE_VMID: ctx_eq = vmid_eq;
            BASE_BOTH: ctx_eq = ctxid_eq & vmid_eq;
            default:   ctx_eq = 1'b0;
        endcase
    end

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
    import bkpt_pkg::*;
#(
    parameter int NUM_PAIRS = 6,
    parameter int PC_W      = 48,
    parameter int VAL_W     = 64,
    parameter int CTX_W     = 32,
    parameter int VMID_W    = 8,
    localparam int IDX_W    = $clog2(NUM_PAIRS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_sel_val,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [VAL_W-1:0]     reg_wdata,
    output logic [VAL_W-1:0]     reg_rdata,
    input  logic                 fetch_valid,
    input  logic [PC_W-1:0]      fetch_pc,
    input  logic [CTX_W-1:0]     fetch_ctxid,
    input  logic [VMID_W-1:0]    fetch_vmid,
    output logic [NUM_PAIRS-1:0] hit_vec,
    output logic                 bkpt_event
);

    typedef struct packed {
        logic [NUM_PAIRS-1:0] hits;
        logic                 evt;
    } out_t;

    bp_ctrl_t [NUM_PAIRS-1:0]        ctrl_q;
    logic [NUM_PAIRS-1:0][VAL_W-1:0] val_q;
    bp_kind_t [NUM_PAIRS-1:0]        kind;
    logic [NUM_PAIRS-1:0]            addr_eq, ctx_eq, tgt_ok, link_ok, cand;
    out_t                            out_d, out_q;

    bkpt_regfile #(
        .NUM_PAIRS (NUM_PAIRS),
        .VAL_W     (VAL_W),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk     (clk),
        .wr_en   (reg_wr),
        .sel_val (reg_sel_val),
        .idx     (reg_idx),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .ctrl_o  (ctrl_q),
        .val_o   (val_q)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        bkpt_pair_cmp #(
            .PC_W   (PC_W),
            .VAL_W  (VAL_W),
            .CTX_W  (CTX_W),
            .VMID_W (VMID_W)
        ) u_cmp (
            .ctrl    (ctrl_q[g]),
            .val     (val_q[g]),
            .pc      (fetch_pc),
            .ctxid   (fetch_ctxid),
            .vmid    (fetch_vmid),
            .kind    (kind[g]),
            .addr_eq (addr_eq[g]),
            .ctx_eq  (ctx_eq[g])
        );

        // R4: a cleared enable bit keeps the slot silent
        a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_valid && !ctrl_q[g].en) |=> !hit_vec[g])
            else $error("slot %0d hit while disabled", g);

        // R9: linked context types only serve as link targets
        a_r9_linked_ctx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_valid && ctrl_q[g].kind[0] && (ctrl_q[g].kind[3] || ctrl_q[g].kind[1]))
            |=> !hit_vec[g])
            else $error("slot %0d linked context type hit on its own", g);

        // R10: mismatch combined with a context base is reserved
        a_r10_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_valid && ctrl_q[g].kind[2] && (ctrl_q[g].kind[3] || ctrl_q[g].kind[1]))
            |=> !hit_vec[g])
            else $error("slot %0d reserved type hit", g);
    end

    // Link resolution and per-slot hit candidates.
    always_comb begin
        for (int j = 0; j < NUM_PAIRS; j++) begin
            tgt_ok[j] = ctrl_q[j].en & kind[j].legal & kind[j].linked
                      & (kind[j].base != BASE_ADDR) & ctx_eq[j];
        end
        for (int i = 0; i < NUM_PAIRS; i++) begin
            link_ok[i] = 1'b0;
            for (int j = 0; j < NUM_PAIRS; j++) begin
                if (int'(ctrl_q[i].link_idx) == j) begin
                    link_ok[i] = tgt_ok[j];
                end
            end
            if (kind[i].base == BASE_ADDR) begin
                cand[i] = ctrl_q[i].en & kind[i].legal & (addr_eq[i] ^ kind[i].mism)
                        & (~kind[i].linked | link_ok[i]);
            end else begin
                cand[i] = ctrl_q[i].en & kind[i].legal & ~kind[i].linked & ctx_eq[i];
            end
        end
    end

    always_comb begin
        out_d      = out_q;
        out_d.hits = fetch_valid ? cand : '0;
        out_d.evt  = fetch_valid & (|cand);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign hit_vec    = out_q.hits;
    assign bkpt_event = out_q.evt;

    // R11: an idle fetch cycle clears every hit
    a_r11_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (hit_vec == '0))
        else $error("hit without a valid fetch");

    // R12: the event agrees with the hit vector
    a_r12_event_matches: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_event == (hit_vec != '0))
        else $error("event disagrees with hit vector");

endmodule

// File: tb/sim_bkpt_match_unit.sv
module sim_bkpt_match_unit;

    localparam int NP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel_val = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [47:0] fetch_pc = '0;
    logic [31:0] fetch_ctxid = '0;
    logic [7:0]  fetch_vmid = '0;
    logic [5:0]  hit_vec;
    logic        bkpt_event;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bkpt_match_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel_val (reg_sel_val),
        .reg_idx     (reg_idx),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .fetch_ctxid (fetch_ctxid),
        .fetch_vmid  (fetch_vmid),
        .hit_vec     (hit_vec),
        .bkpt_event  (bkpt_event)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    bit [31:0] m_ctrl [NP];
    bit [63:0] m_val  [NP];
    bit [5:0]  exp_q;

    function automatic bit [31:0] norm(input bit [31:0] w);
        bit [31:0] r;
        r    = w & 32'h00FF_E0A7;
        r[8] = r[7];
        r[6] = r[5];
        return r;
    endfunction

    function automatic bit m_ctx(input int j, input bit [31:0] cx, input bit [7:0] vm);
        bit [3:0] t;
        t = m_ctrl[j][23:20];
        case ({t[3], t[1]})
            2'b01:   return cx == m_val[j][31:0];
            2'b10:   return vm == m_val[j][39:32];
            2'b11:   return (cx == m_val[j][31:0]) && (vm == m_val[j][39:32]);
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit [5:0] model(input bit [47:0] pc, input bit [31:0] cx, input bit [7:0] vm);
        bit [5:0] r;
        r = '0;
        for (int i = 0; i < NP; i++) begin
            bit [31:0] c;
            int        t, lbn;
            bit        a, lk, h;
            c   = m_ctrl[i];
            t   = int'(c[23:20]);
            lbn = int'(c[19:16]);
            a   = (pc[47:2] == m_val[i][47:2]) && (pc[1] ? c[7] : c[5]);
            lk  = 1'b0;
            if (lbn < NP) begin
                int tt;
                tt = int'(m_ctrl[lbn][23:20]);
                lk = m_ctrl[lbn][0] && (tt == 3 || tt == 9 || tt == 11) && m_ctx(lbn, cx, vm);
            end
            case (t)
                0:         h = a;
                4:         h = !a;
                1:         h = a && lk;
                5:         h = !a && lk;
                2, 8, 10:  h = m_ctx(i, cx, vm);
                default:   h = 1'b0;
            endcase
            r[i] = c[0] && h;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) exp_q <= '0;
        else        exp_q <= fetch_valid ? model(fetch_pc, fetch_ctxid, fetch_vmid) : '0;
        if (rst_n && reg_wr && int'(reg_idx) < NP) begin
            if (reg_sel_val) m_val[reg_idx]  <= reg_wdata;
            else             m_ctrl[reg_idx] <= norm(reg_wdata[31:0]);
        end
    end

    // Per-cycle comparison against the model (R11, R12 and every hit rule)
    always @(negedge clk) begin
        if (rst_n) begin
            chk((hit_vec == exp_q) && (bkpt_event == (exp_q != 0)), "R11 R12 model compare",
                {57'd0, bkpt_event, hit_vec}, {57'd0, exp_q != 0, exp_q});
        end
    end

    function automatic bit [31:0] cw(input bit en, input bit [3:0] t, input bit [3:0] lbn, input bit [3:0] bas);
        return {8'h00, t, lbn, 3'b000, 4'b0000, bas, 2'b00, 2'b00, en};
    endfunction

    task automatic wr(input bit sv, input int idx, input bit [63:0] d);
        @(negedge clk);
        reg_wr      = 1'b1;
        reg_sel_val = sv;
        reg_idx     = idx[2:0];
        reg_wdata   = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic setc(input int i, input bit en, input bit [3:0] t, input bit [3:0] lbn, input bit [3:0] bas);
        wr(1'b0, i, {32'h0, cw(en, t, lbn, bas)});
    endtask

    task automatic rdchk(input bit sv, input int idx, input bit [63:0] exp, input string tag);
        @(negedge clk);
        reg_sel_val = sv;
        reg_idx     = idx[2:0];
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic fx(input bit [47:0] pc, input bit [31:0] cx, input bit [7:0] vm,
                      input bit [5:0] e, input string tag);
        @(negedge clk);
        fetch_pc    = pc;
        fetch_ctxid = cx;
        fetch_vmid  = vm;
        fetch_valid = 1'b1;
        #1;
        chk(hit_vec == 6'd0, "R11 no hit before capture edge", {58'd0, hit_vec}, 64'd0);
        @(negedge clk);
        fetch_valid = 1'b0;
        chk(hit_vec == e, tag, {58'd0, hit_vec}, {58'd0, e});
        chk(bkpt_event == (e != 0), "R12 event", {63'd0, bkpt_event}, {63'd0, e != 0});
    endtask

    task automatic clear_all();
        for (int i = 0; i < NP; i++) begin
            setc(i, 1'b0, 4'h0, 4'h0, 4'h0);
            wr(1'b1, i, 64'h0);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(hit_vec == 6'd0, "R1 reset hits", {58'd0, hit_vec}, 64'd0);
        chk(bkpt_event == 1'b0, "R1 reset event", {63'd0, bkpt_event}, 64'd0);
        rst_n = 1'b1;
        clear_all();

        // R2 control readback and halfword-select mirroring
        wr(1'b0, 5, 64'hFFFF_FFFF_FFFF_FFFF);
        rdchk(1'b0, 5, 64'h0000_0000_00FF_E1E7, "R2 all ones readback");
        wr(1'b0, 5, 64'h20);
        rdchk(1'b0, 5, 64'h60, "R2 low select mirrors");
        wr(1'b0, 5, 64'h40);
        rdchk(1'b0, 5, 64'h0, "R2 bit6 write ignored");
        wr(1'b0, 5, 64'h100);
        rdchk(1'b0, 5, 64'h0, "R2 bit8 write ignored");
        wr(1'b0, 5, 64'h80);
        rdchk(1'b0, 5, 64'h180, "R2 high select mirrors");
        // R3 value readback
        wr(1'b1, 4, 64'hDEAD_BEEF_0123_4567);
        rdchk(1'b1, 4, 64'hDEAD_BEEF_0123_4567, "R3 value readback");
        rdchk(1'b1, 0, 64'h0, "R3 untouched value");
        clear_all();

        // R5 address equality with halfword select
        wr(1'b1, 0, 64'h1000);
        setc(0, 1'b1, 4'h0, 4'h0, 4'b0011);
        // R11 idle with a matching address
        @(negedge clk);
        fetch_pc = 48'h1000;
        repeat (3) begin
            @(negedge clk);
            chk(hit_vec == 6'd0, "R11 idle with match", {58'd0, hit_vec}, 64'd0);
        end
        fx(48'h1000, 0, 0, 6'b000001, "R5 lower half");
        fx(48'h1002, 0, 0, 6'b000000, "R5 upper half unselected");
        setc(0, 1'b1, 4'h0, 4'h0, 4'b1100);
        fx(48'h1002, 0, 0, 6'b000001, "R5 upper half selected");
        fx(48'h1000, 0, 0, 6'b000000, "R5 lower half unselected");
        setc(0, 1'b1, 4'h0, 4'h0, 4'b1111);
        fx(48'h1000, 0, 0, 6'b000001, "R5 full word low");
        fx(48'h1002, 0, 0, 6'b000001, "R5 full word high");
        fx(48'h1004, 0, 0, 6'b000000, "R5 next word");
        fx(48'h8000_0000_1000, 0, 0, 6'b000000, "R5 upper bits differ");
        // R4 disabled
        setc(0, 1'b0, 4'h0, 4'h0, 4'b1111);
        fx(48'h1000, 0, 0, 6'b000000, "R4 disabled address");

        // R6 inequality
        wr(1'b1, 1, 64'h2000);
        setc(1, 1'b1, 4'h4, 4'h0, 4'b1111);
        fx(48'h2000, 0, 0, 6'b000000, "R6 equal address");
        fx(48'h2002, 0, 0, 6'b000000, "R6 equal upper half");
        fx(48'h3000, 0, 0, 6'b000010, "R6 other address");
        setc(1, 1'b0, 4'h4, 4'h0, 4'b1111);

        // R7 context comparisons
        wr(1'b1, 2, 64'h0000_00AB_1234_5678);
        setc(2, 1'b1, 4'h2, 4'h0, 4'b1111);
        fx(48'h0, 32'h1234_5678, 8'h00, 6'b000100, "R7 ctxid match");
        fx(48'h0, 32'h1234_5679, 8'hAB, 6'b000000, "R7 ctxid differ");
        setc(2, 1'b1, 4'h8, 4'h0, 4'b1111);
        fx(48'h0, 32'h0, 8'hAB, 6'b000100, "R7 vmid match");
        fx(48'h0, 32'h1234_5678, 8'hAC, 6'b000000, "R7 vmid differ");
        setc(2, 1'b1, 4'hA, 4'h0, 4'b1111);
        fx(48'h0, 32'h1234_5678, 8'hAB, 6'b000100, "R7 both match");
        fx(48'h0, 32'h1234_5678, 8'hAC, 6'b000000, "R7 both vmid off");
        setc(2, 1'b0, 4'h2, 4'h0, 4'b1111);
        fx(48'h0, 32'h1234_5678, 8'h00, 6'b000000, "R4 disabled context");

        // R8 and R9 linking
        wr(1'b1, 3, 64'h55);
        setc(3, 1'b1, 4'h3, 4'h0, 4'b1111);
        wr(1'b1, 4, 64'h4000);
        setc(4, 1'b1, 4'h1, 4'h3, 4'b0011);
        fx(48'h4000, 32'h55, 0, 6'b010000, "R8 linked address hit");
        fx(48'h4000, 32'h56, 0, 6'b000000, "R8 link context false");
        fx(48'h4008, 32'h55, 0, 6'b000000, "R9 linked context silent");
        setc(4, 1'b1, 4'h5, 4'h3, 4'b1111);
        fx(48'h5000, 32'h55, 0, 6'b010000, "R8 linked inequality hit");
        fx(48'h5000, 32'h56, 0, 6'b000000, "R8 linked inequality no context");
        setc(4, 1'b1, 4'h1, 4'h3, 4'b0011);
        setc(3, 1'b0, 4'h3, 4'h0, 4'b1111);
        fx(48'h4000, 32'h55, 0, 6'b000000, "R8 target disabled");
        setc(3, 1'b1, 4'h2, 4'h0, 4'b1111);
        fx(48'h4000, 32'h55, 0, 6'b001000, "R8 target unlinked type");
        setc(3, 1'b1, 4'h3, 4'h0, 4'b1111);
        setc(4, 1'b1, 4'h1, 4'h7, 4'b0011);
        fx(48'h4000, 32'h55, 0, 6'b000000, "R8 link index 7");
        setc(4, 1'b1, 4'h1, 4'h6, 4'b0011);
        fx(48'h4000, 32'h55, 0, 6'b000000, "R8 link index 6");
        wr(1'b1, 5, 64'h0000_0022_0000_0000);
        setc(5, 1'b1, 4'h9, 4'h0, 4'b1111);
        setc(4, 1'b1, 4'h1, 4'h5, 4'b0011);
        fx(48'h4000, 32'h0, 8'h22, 6'b010000, "R8 vmid target hit");
        fx(48'h4000, 32'h0, 8'h23, 6'b000000, "R8 vmid target false");
        clear_all();

        // R10 reserved types
        wr(1'b1, 0, 64'h1000);
        setc(0, 1'b1, 4'h6, 4'h0, 4'b1111);
        fx(48'h3000, 0, 0, 6'b000000, "R10 type 0110");
        setc(0, 1'b1, 4'hC, 4'h0, 4'b1111);
        fx(48'h1000, 0, 0, 6'b000000, "R10 type 1100");
        setc(0, 1'b1, 4'hF, 4'h0, 4'b1111);
        fx(48'h1000, 0, 0, 6'b000000, "R10 type 1111");

        // R12 several slots together
        setc(0, 1'b1, 4'h0, 4'h0, 4'b1111);
        wr(1'b1, 1, 64'h1000);
        setc(1, 1'b1, 4'h0, 4'h0, 4'b0011);
        fx(48'h1000, 0, 0, 6'b000011, "R12 two slots");
        fx(48'h1002, 0, 0, 6'b000001, "R12 one slot");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule